// File: doc/BRIEF.md
# Non-Inclusive Second-Level Cache Controller

This block is a four-way set-associative, write-back second-level cache that sits between a primary data cache and main memory. It serves two kinds of request from the primary side. A line fill asks for a whole line. A dirty writeback hands a whole line down. Each request carries a caching attribute, and a flag that tells whether the primary will hold the line dirty. Memory is reached through line-granular reads and writes that use a request/grant handshake, and read data comes back on a separate valid strobe.

The cache does not keep the primaries as a subset of its own contents. A fill may replace the entry that belonged to another primary line, and that primary line is left alone. Each tag entry records whether its line is also held dirty in the primary. If such an entry is chosen as a dirty victim, it is dropped without a memory write, because the primary still has the newest copy. When that orphaned primary line is later written back, the writeback misses here and goes straight to memory. Only the block write-back attribute uses the cache. Uncached traffic, both write-through attributes and the bypass attribute pass straight to memory.

Tag entries carry two even-parity bits. The data array stores one parity bit per 64-bit doubleword. Array depth, associativity and data width are parameters.

Top module: `l2nc_cache`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1, `rsp_valid` is 0, `mem_req` is 0 and every tag entry is invalid.
- R2: A fill with attribute 3'd3 (write-back) that hits returns the cached line with `rsp_hit`=1 and makes no memory request.
- R3: A write-back fill that misses reads the line from memory, installs it as clean, and returns it with `rsp_hit`=0. A later fill of that line then hits.
- R4: A write-back writeback that hits updates the cached line and marks it dirty, with no memory write. A later fill returns the new data.
- R5: A write-back writeback that misses is written to memory at the request address and is not allocated. A later fill of that line misses.
- R6: The attributes 3'd0 (write-through, no allocate), 3'd1 (write-through, allocate), 3'd2 (uncached) and 3'd7 (write-back with bypass), and any other code except 3'd3, never search, fill or write the cache. Every fill reads memory, every writeback writes memory, and any cached copy of the line is left unchanged.
- R7: On a fill miss the victim is the lowest-numbered invalid way. If no way is invalid, the victim is the way named by a per-set round-robin pointer. The pointer starts at way 0 and advances by one (wrapping) each time a valid way is replaced.
- R8: A dirty victim that is not flagged as dirty in the primary is written to memory at its own address before the fill's memory read.
- R9: A dirty victim whose entry records that the primary holds it dirty (set by a fill with `req_pri_dirty`=1, cleared by a writeback hit) is dropped with no memory write.
- R10: Tag parity bit 0 is the XOR of the 20-bit address tag. Tag parity bit 1 is the XOR of the 2 housekeeping bits and the 3-bit state. Data parity is the XOR of each doubleword. `parity_err` pulses only when a cacheable lookup finds a mismatch, so it stays 0 on intact arrays.
- R11: Once raised, `mem_req` stays high with `mem_we`, `mem_addr` and `mem_wdata` unchanged until a cycle with `mem_gnt`=1.
- R12: One request is handled at a time. `req_ready` drops in the cycle after a request is accepted, and `rsp_valid` is a single-cycle pulse, after which `req_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Primary request present |
| req_ready | output | 1 | Controller idle; request accepted when both are high |
| req_is_wb | input | 1 | 1 = dirty writeback, 0 = line fill |
| req_attr | input | 3 | Caching attribute code |
| req_pri_dirty | input | 1 | Fill: primary will hold the line dirty |
| req_addr | input | TAG_W+log2(SETS) | Line address (tag above index) |
| req_wdata | input | DW*BEATS | Writeback line data |
| rsp_valid | output | 1 | Request completed (one cycle) |
| rsp_hit | output | 1 | Request was served by the cache |
| rsp_data | output | DW*BEATS | Fill data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_addr | output | TAG_W+log2(SETS) | Memory line address |
| mem_wdata | output | DW*BEATS | Memory write line |
| mem_rvalid | input | 1 | Read line returned (not before the cycle after grant) |
| mem_rdata | input | DW*BEATS | Returned read line |
| parity_err | output | 1 | Tag or data parity mismatch at lookup |

## Verification
On every cycle, the embedded properties check the memory handshake hold, the single-cycle response and busy behaviour, and the absence of parity errors. They also check that a cacheable hit goes to its response without memory traffic, that non-cacheable traffic never writes either array, that no two ways of a set hit at once, that the round-robin pointer only moves when a set is full, and that a victim write only happens for a dirty line not held in the primary. Only the bench scenarios can show the results that depend on history: data written by a writeback coming back on a later fill, the exact round-robin eviction order across repeated misses, a dirty victim being dropped and the orphaned line later reaching memory without allocation, and a bypass writeback leaving the cached copy unchanged.

// File: rtl/l2nc_pkg.sv
// Shared types for the non-inclusive second-level cache.
// Assumes a fixed 20-bit address tag, 2 housekeeping bits, 3-bit state.
package l2nc_pkg;
    localparam int TAG_W = 20;
    localparam int HK_W  = 2;
    localparam int ST_W  = 3;

    // Caching attribute codes; only ATTR_WB uses the cache.
    localparam logic [2:0] ATTR_WT_NA  = 3'd0;
    localparam logic [2:0] ATTR_WT_AL  = 3'd1;
    localparam logic [2:0] ATTR_UNC    = 3'd2;
    localparam logic [2:0] ATTR_WB     = 3'd3;
    localparam logic [2:0] ATTR_WB_BYP = 3'd7;

    // Line state encodings.
    localparam logic [ST_W-1:0] ST_INV   = 3'b000;
    localparam logic [ST_W-1:0] ST_CLEAN = 3'b001;
    localparam logic [ST_W-1:0] ST_DIRTY = 3'b011;

    // hk[0]: primary holds this line dirty; hk[1]: last written by a writeback.
    typedef struct packed {
        logic [1:0]      par;
        logic [ST_W-1:0] st;
        logic [HK_W-1:0] hk;
        logic [TAG_W-1:0] tag;
    } tag_ent_t;

    // Build a tag entry with even parity: par[0] over tag, par[1] over hk and state.
    function automatic tag_ent_t mk_ent(input logic [TAG_W-1:0] tag,
                                        input logic [HK_W-1:0] hk,
                                        input logic [ST_W-1:0] st);
        tag_ent_t e;
        e.tag = tag;
        e.hk  = hk;
        e.st  = st;
        e.par = {^{hk, st}, ^tag};
        return e;
    endfunction

    typedef enum logic [2:0] {
        FS_IDLE, FS_LOOKUP, FS_VIC_WR, FS_MEM_WR, FS_RD_REQ, FS_RD_WAIT, FS_RESP
    } fsm_t;
endpackage

// File: rtl/l2nc_tag_store.sv
// Tag array with per-way lookup, parity check and victim choice.
// Assumes all reads and writes of one request use the same set index,
// and WAYS >= 2. Invalid ways win over the per-set round-robin pointer.
module l2nc_tag_store
    import l2nc_pkg::*;
#(
    parameter int SETS = 16,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output tag_ent_t          hit_ent,
    output logic [WAY_W-1:0]  vic_way,
    output tag_ent_t          vic_ent,
    output logic              tag_perr,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  tag_ent_t          wr_ent,
    input  logic              rr_adv
);
    tag_ent_t [WAYS-1:0] tarr [SETS];
    logic     [WAY_W-1:0] rr  [SETS];
    logic [WAYS-1:0] hit_vec, inv_vec, perr_vec;
    logic [WAY_W-1:0] inv_way;

    // Per-way compare, invalid detect and parity recompute.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tag_ent_t ent;
        assign ent         = tarr[lk_idx][w];
        assign inv_vec[w]  = (ent.st == ST_INV);
        assign hit_vec[w]  = !inv_vec[w] && (ent.tag == lk_tag);
        assign perr_vec[w] = !inv_vec[w] && (ent.par != {^{ent.hk, ent.st}, ^ent.tag});
    end

    // Encode the lowest hitting way and the lowest invalid way.
    always_comb begin
        hit_way = '0;
        inv_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
            if (inv_vec[w]) inv_way = WAY_W'(w);
        end
    end

    assign hit      = |hit_vec;
    assign tag_perr = |perr_vec;
    assign vic_way  = (|inv_vec) ? inv_way : rr[lk_idx];
    assign hit_ent  = tarr[lk_idx][hit_way];
    assign vic_ent  = tarr[lk_idx][vic_way];

    // Array and pointer update; reset clears every entry to invalid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                tarr[s] <= '0;
                rr[s]   <= '0;
            end
        end else begin
            if (wr_en) tarr[lk_idx][wr_way] <= wr_ent;
            if (rr_adv) rr[lk_idx] <= (rr[lk_idx] == WAY_W'(WAYS - 1)) ? '0 : rr[lk_idx] + 1'b1;
        end
    end

    AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R3
    AST_RR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rr_adv |-> (inv_vec == '0)); // R7
endmodule

// File: rtl/l2nc_data_store.sv
// Line data array with one even-parity bit per doubleword.
// Assumes reads and writes share one index; contents are don't-care until
// a line is installed, so the array has no reset.
module l2nc_data_store #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int DW    = 64,
    parameter int BEATS = 4,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int LINE_W = DW * BEATS
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WAY_W-1:0]  rd_way,
    output logic [LINE_W-1:0] rd_line,
    output logic              rd_perr,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [LINE_W-1:0] wr_line
);
    logic [LINE_W-1:0] darr [SETS][WAYS];
    logic [BEATS-1:0]  parr [SETS][WAYS];
    logic [BEATS-1:0]  wr_par, rd_calc;

    // Per-doubleword parity for the write and read paths.
    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        assign wr_par[b]  = ^wr_line[b*DW +: DW];
        assign rd_calc[b] = ^rd_line[b*DW +: DW];
    end

    assign rd_line = darr[idx][rd_way];
    assign rd_perr = |(rd_calc ^ parr[idx][rd_way]);

    // Store line and its parity together.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            darr[idx][wr_way] <= wr_line;
            parr[idx][wr_way] <= wr_par;
        end
    end
endmodule

// File: rtl/l2nc_cache.sv
// Non-inclusive write-back second-level cache controller.
// Handles one primary request at a time: lookup, optional victim write,
// memory read and install. Assumes mem_rvalid never comes before the
// cycle after the read grant, and that request fields are sampled on accept.
module l2nc_cache
    import l2nc_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int DW    = 64,
    parameter int BEATS = 4,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int LINE_W = DW * BEATS,
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_wb,
    input  logic [2:0]        req_attr,
    input  logic              req_pri_dirty,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LINE_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [LINE_W-1:0] rsp_data,
    output logic              mem_req,
    output logic              mem_we,
    input  logic              mem_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [LINE_W-1:0] mem_rdata,
    output logic              parity_err
);
    fsm_t st_q, st_d;

    logic              q_wb, q_pd;
    logic [2:0]        q_attr;
    logic [ADDR_W-1:0] q_addr;
    logic [LINE_W-1:0] q_wdata;
    logic [IDX_W-1:0]  q_idx;
    logic [TAG_W-1:0]  q_tag;
    logic              cacheable;

    logic [WAY_W-1:0]  v_way_q;
    logic [TAG_W-1:0]  v_tag_q;
    logic              v_valid_q, v_dirty_q, v_pdirty_q;
    logic [LINE_W-1:0] line_q;
    logic              hit_q;

    logic              t_hit, t_perr;
    logic [WAY_W-1:0]  t_hit_way, t_vic_way;
    tag_ent_t          t_hit_ent, t_vic_ent;
    logic              tag_we, rr_adv;
    logic [WAY_W-1:0]  tag_wway;
    tag_ent_t          tag_went;

    logic [LINE_W-1:0] d_rd_line;
    logic              d_perr, data_we;
    logic [WAY_W-1:0]  data_wway;
    logic [LINE_W-1:0] data_wline;
    logic              vic_needs_wb;

    assign q_idx     = q_addr[IDX_W-1:0];
    assign q_tag     = q_addr[ADDR_W-1 -: TAG_W];
    assign cacheable = (q_attr == ATTR_WB);

    l2nc_tag_store #(.SETS(SETS), .WAYS(WAYS)) u_tags (
        .clk(clk), .rst_n(rst_n), .lk_idx(q_idx), .lk_tag(q_tag),
        .hit(t_hit), .hit_way(t_hit_way), .hit_ent(t_hit_ent),
        .vic_way(t_vic_way), .vic_ent(t_vic_ent), .tag_perr(t_perr),
        .wr_en(tag_we), .wr_way(tag_wway), .wr_ent(tag_went), .rr_adv(rr_adv)
    );

    l2nc_data_store #(.SETS(SETS), .WAYS(WAYS), .DW(DW), .BEATS(BEATS)) u_data (
        .clk(clk), .idx(q_idx), .rd_way(t_hit ? t_hit_way : t_vic_way),
        .rd_line(d_rd_line), .rd_perr(d_perr),
        .wr_en(data_we), .wr_way(data_wway), .wr_line(data_wline)
    );

    // A dirty victim goes to memory only if the primary does not hold it dirty.
    assign vic_needs_wb = (t_vic_ent.st == ST_DIRTY) && !t_vic_ent.hk[0];

    // Next state and array write controls.
    always_comb begin
        st_d       = st_q;
        tag_we     = 1'b0;
        tag_wway   = t_hit_way;
        tag_went   = t_hit_ent;
        data_we    = 1'b0;
        data_wway  = t_hit_way;
        data_wline = q_wdata;
        rr_adv     = 1'b0;
        unique case (st_q)
            FS_IDLE:   if (req_valid) st_d = FS_LOOKUP;
            FS_LOOKUP: begin
                if (!cacheable) begin
                    st_d = q_wb ? FS_MEM_WR : FS_RD_REQ;
                end else if (t_hit) begin
                    st_d   = FS_RESP;
                    tag_we = 1'b1;
                    if (q_wb) begin
                        tag_went = mk_ent(t_hit_ent.tag, 2'b10, ST_DIRTY);
                        data_we  = 1'b1;
                    end else begin
                        tag_went = mk_ent(t_hit_ent.tag, {t_hit_ent.hk[1], q_pd}, t_hit_ent.st);
                    end
                end else if (q_wb) begin
                    st_d = FS_MEM_WR;
                end else begin
                    st_d = vic_needs_wb ? FS_VIC_WR : FS_RD_REQ;
                end
            end
            FS_VIC_WR: if (mem_gnt) st_d = FS_RD_REQ;
            FS_MEM_WR: if (mem_gnt) st_d = FS_RESP;
            FS_RD_REQ: if (mem_gnt) st_d = FS_RD_WAIT;
            FS_RD_WAIT: begin
                if (mem_rvalid) begin
                    st_d = FS_RESP;
                    if (cacheable) begin
                        tag_we     = 1'b1;
                        tag_wway   = v_way_q;
                        tag_went   = mk_ent(q_tag, {1'b0, q_pd}, ST_CLEAN);
                        data_we    = 1'b1;
                        data_wway  = v_way_q;
                        data_wline = mem_rdata;
                        rr_adv     = v_valid_q;
                    end
                end
            end
            FS_RESP:   st_d = FS_IDLE;
            default:   st_d = FS_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FS_IDLE;
        else        st_q <= st_d;
    end

    // Capture the request on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_wb <= 1'b0; q_pd <= 1'b0; q_attr <= '0; q_addr <= '0; q_wdata <= '0;
        end else if (st_q == FS_IDLE && req_valid) begin
            q_wb <= req_is_wb; q_pd <= req_pri_dirty; q_attr <= req_attr;
            q_addr <= req_addr; q_wdata <= req_wdata;
        end
    end

    // Capture victim, hit line and returned memory line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_way_q <= '0; v_tag_q <= '0; v_valid_q <= 1'b0; v_dirty_q <= 1'b0;
            v_pdirty_q <= 1'b0; line_q <= '0; hit_q <= 1'b0;
        end else if (st_q == FS_LOOKUP) begin
            v_way_q    <= t_vic_way;
            v_tag_q    <= t_vic_ent.tag;
            v_valid_q  <= (t_vic_ent.st != ST_INV);
            v_dirty_q  <= (t_vic_ent.st == ST_DIRTY);
            v_pdirty_q <= t_vic_ent.hk[0];
            line_q     <= d_rd_line;
            hit_q      <= cacheable && t_hit;
        end else if (st_q == FS_RD_WAIT && mem_rvalid) begin
            line_q <= mem_rdata;
        end
    end

    assign req_ready  = (st_q == FS_IDLE);
    assign rsp_valid  = (st_q == FS_RESP);
    assign rsp_hit    = hit_q;
    assign rsp_data   = line_q;
    assign mem_req    = (st_q == FS_VIC_WR) || (st_q == FS_MEM_WR) || (st_q == FS_RD_REQ);
    assign mem_we     = (st_q != FS_RD_REQ);
    assign mem_addr   = (st_q == FS_VIC_WR) ? {v_tag_q, q_idx} : q_addr;
    assign mem_wdata  = (st_q == FS_VIC_WR) ? line_q : q_wdata;
    assign parity_err = (st_q == FS_LOOKUP) && cacheable && (t_perr || (t_hit && d_perr));

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))); // R11
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)); // R12
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R12
    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_LOOKUP && cacheable && t_hit) |=> (!mem_req && rsp_valid)); // R2
    AST_BYPASS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_we || data_we) |-> cacheable); // R6
    AST_VICTIM_WB_COND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_VIC_WR) |-> (v_dirty_q && !v_pdirty_q)); // R9
    AST_NO_PERR: assert property (@(posedge clk) disable iff (!rst_n)
        !parity_err); // R10
endmodule

// File: tb/l2nc_cache_tb.sv
`timescale 1ns/1ps
module l2nc_cache_tb;
    localparam int AW = 24;
    localparam int LW = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          req_valid = 1'b0, req_is_wb = 1'b0, req_pri_dirty = 1'b0;
    logic [2:0]    req_attr = 3'd3;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid, rsp_hit, mem_req, mem_we, mem_gnt, parity_err;
    logic [LW-1:0] rsp_data, mem_wdata;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [LW-1:0] mem_rdata = '0;

    l2nc_cache u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_wb(req_is_wb), .req_attr(req_attr), .req_pri_dirty(req_pri_dirty),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_data(rsp_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .parity_err(parity_err)
    );

    int n_chk = 0, n_fail = 0;
    int rd_cnt = 0, wr_cnt = 0, hold_viol = 0, perr_cnt = 0, busy_viol = 0;
    logic [AW-1:0] last_wr_addr = '0;
    logic [LW-1:0] mstore [logic [AW-1:0]];
    logic gnt_tog = 1'b0, rd_pend = 1'b0, p_req = 1'b0, p_gnt = 1'b0;
    logic [AW-1:0] rd_a = '0;

    function automatic logic [LW-1:0] pat(input logic [AW-1:0] a);
        logic [31:0] b = {8'h5C, a};
        return {b, b + 1, b + 2, b + 3, b + 4, b + 5, b + 6, b + 7};
    endfunction
    function automatic logic [LW-1:0] wdat(input logic [31:0] k);
        return {8{k}};
    endfunction
    function automatic logic [AW-1:0] la(input logic [19:0] t, input logic [3:0] i);
        return {t, i};
    endfunction

    // Memory model: grant every other cycle, read data one cycle after grant.
    assign mem_gnt = mem_req && gnt_tog;
    always @(posedge clk) begin
        gnt_tog <= ~gnt_tog;
        mem_rvalid <= rd_pend;
        mem_rdata  <= mstore.exists(rd_a) ? mstore[rd_a] : pat(rd_a);
        rd_pend <= 1'b0;
        if (mem_req && mem_gnt) begin
            if (mem_we) begin
                mstore[mem_addr] = mem_wdata;
                wr_cnt++;
                last_wr_addr = mem_addr;
            end else begin
                rd_cnt++;
                rd_pend <= 1'b1;
                rd_a    <= mem_addr;
            end
        end
    end

    // Monitor handshake hold and parity flag between edges.
    always @(negedge clk) begin
        if (rst_n && p_req && !p_gnt && !mem_req) hold_viol++;
        if (rst_n && parity_err) perr_cnt++;
        p_req = mem_req;
        p_gnt = mem_gnt;
    end

    task automatic chk(input bit ok, input string rq, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic do_req(input bit wb, input logic [2:0] attr, input bit pd, input logic [AW-1:0] a,
                          input logic [LW-1:0] d, output bit hit, output logic [LW-1:0] data);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_is_wb = wb; req_attr = attr; req_pri_dirty = pd;
        req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (req_ready) busy_viol++;
        while (!rsp_valid) @(negedge clk);
        hit = rsp_hit;
        data = rsp_data;
        @(negedge clk);
        if (rsp_valid || !req_ready) busy_viol++;
    endtask

    // Fill and check hit flag and data.
    task automatic fill_chk(input logic [2:0] attr, input bit pd, input logic [AW-1:0] a,
                            input bit exp_hit, input logic [LW-1:0] exp_d, input string rq);
        bit h; logic [LW-1:0] d;
        do_req(1'b0, attr, pd, a, '0, h, d);
        chk(h == exp_hit, {rq, " hit"}, LW'(h), LW'(exp_hit));
        chk(d == exp_d, {rq, " data"}, d, exp_d);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 req_ready", LW'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", LW'(rsp_valid), 0);
        chk(mem_req == 1'b0, "R1 mem_req", LW'(mem_req), 0);
    endtask

    task automatic t_fill_hit();
        logic [AW-1:0] a = la(20'h00011, 4'd1);
        int r0 = rd_cnt;
        fill_chk(3'd3, 1'b0, a, 1'b0, pat(a), "R3 miss fill");
        chk(rd_cnt == r0 + 1, "R3 one read", LW'(rd_cnt), LW'(r0 + 1));
        fill_chk(3'd3, 1'b0, a, 1'b1, pat(a), "R2 hit fill");
        chk(rd_cnt == r0 + 1, "R2 no read on hit", LW'(rd_cnt), LW'(r0 + 1));
    endtask

    task automatic t_wb_hit();
        logic [AW-1:0] a = la(20'h00011, 4'd1);
        bit h; logic [LW-1:0] d;
        int w0 = wr_cnt;
        do_req(1'b1, 3'd3, 1'b0, a, wdat(32'hD1D1_0001), h, d);
        chk(h == 1'b1, "R4 wb hit", LW'(h), 1);
        chk(wr_cnt == w0, "R4 no mem write", LW'(wr_cnt), LW'(w0));
        fill_chk(3'd3, 1'b0, a, 1'b1, wdat(32'hD1D1_0001), "R4 refill");
    endtask

    task automatic t_wb_miss();
        logic [AW-1:0] a = la(20'h00022, 4'd2);
        bit h; logic [LW-1:0] d;
        int w0 = wr_cnt;
        do_req(1'b1, 3'd3, 1'b0, a, wdat(32'hD2D2_0002), h, d);
        chk(h == 1'b0, "R5 wb miss", LW'(h), 0);
        chk(wr_cnt == w0 + 1, "R5 mem write", LW'(wr_cnt), LW'(w0 + 1));
        chk(last_wr_addr == a, "R5 write addr", LW'(last_wr_addr), LW'(a));
        fill_chk(3'd3, 1'b0, a, 1'b0, wdat(32'hD2D2_0002), "R5 not allocated");
    endtask

    task automatic t_noncache();
        logic [AW-1:0] c = la(20'h00033, 4'd3);
        logic [AW-1:0] a = la(20'h00011, 4'd1);
        logic [2:0] attrs [4] = '{3'd0, 3'd1, 3'd2, 3'd7};
        bit h; logic [LW-1:0] d;
        int w0;
        for (int i = 0; i < 4; i++) begin
            int r0 = rd_cnt;
            fill_chk(attrs[i], 1'b0, c, 1'b0, pat(c), "R6 first fill");
            fill_chk(attrs[i], 1'b0, c, 1'b0, pat(c), "R6 repeat fill");
            chk(rd_cnt == r0 + 2, "R6 reads each time", LW'(rd_cnt), LW'(r0 + 2));
        end
        w0 = wr_cnt;
        do_req(1'b1, 3'd7, 1'b0, a, wdat(32'hD3D3_0003), h, d);
        chk(wr_cnt == w0 + 1, "R6 bypass wb to mem", LW'(wr_cnt), LW'(w0 + 1));
        fill_chk(3'd3, 1'b0, a, 1'b1, wdat(32'hD1D1_0001), "R6 cached copy untouched");
    endtask

    task automatic t_replace();
        logic [3:0] s = 4'd5;
        int w0 = wr_cnt;
        for (int i = 0; i < 5; i++)
            fill_chk(3'd3, 1'b0, la(20'h100 + 20'(i), s), 1'b0, pat(la(20'h100 + 20'(i), s)), "R7 fill set");
        fill_chk(3'd3, 1'b0, la(20'h102, s), 1'b1, pat(la(20'h102, s)), "R7 way2 kept");
        fill_chk(3'd3, 1'b0, la(20'h101, s), 1'b1, pat(la(20'h101, s)), "R7 way1 kept");
        fill_chk(3'd3, 1'b0, la(20'h100, s), 1'b0, pat(la(20'h100, s)), "R7 way0 evicted");
        fill_chk(3'd3, 1'b0, la(20'h101, s), 1'b0, pat(la(20'h101, s)), "R7 rr evicted way1");
        fill_chk(3'd3, 1'b0, la(20'h103, s), 1'b1, pat(la(20'h103, s)), "R7 way3 kept");
        chk(wr_cnt == w0, "R7 clean victims not written", LW'(wr_cnt), LW'(w0));
    endtask

    task automatic t_dirty_victim();
        logic [3:0] s = 4'd6;
        bit h; logic [LW-1:0] d;
        int w0, r0;
        for (int i = 0; i < 4; i++)
            fill_chk(3'd3, 1'b0, la(20'h200 + 20'(i), s), 1'b0, pat(la(20'h200 + 20'(i), s)), "R8 fill set");
        do_req(1'b1, 3'd3, 1'b0, la(20'h200, s), wdat(32'hD4D4_0004), h, d);
        w0 = wr_cnt; r0 = rd_cnt;
        fill_chk(3'd3, 1'b0, la(20'h204, s), 1'b0, pat(la(20'h204, s)), "R8 evicting fill");
        chk(wr_cnt == w0 + 1, "R8 victim written", LW'(wr_cnt), LW'(w0 + 1));
        chk(last_wr_addr == la(20'h200, s), "R8 victim addr", LW'(last_wr_addr), LW'(la(20'h200, s)));
        chk(rd_cnt == r0 + 1, "R8 one read", LW'(rd_cnt), LW'(r0 + 1));
        fill_chk(3'd3, 1'b0, la(20'h200, s), 1'b0, wdat(32'hD4D4_0004), "R8 victim data in mem");
    endtask

    task automatic t_dirty_drop();
        logic [3:0] s = 4'd7;
        bit h; logic [LW-1:0] d;
        int w0;
        fill_chk(3'd3, 1'b0, la(20'h300, s), 1'b0, pat(la(20'h300, s)), "R9 first fill");
        do_req(1'b1, 3'd3, 1'b0, la(20'h300, s), wdat(32'hD5D5_0005), h, d);
        fill_chk(3'd3, 1'b1, la(20'h300, s), 1'b1, wdat(32'hD5D5_0005), "R9 refill held dirty");
        for (int i = 1; i < 4; i++)
            fill_chk(3'd3, 1'b0, la(20'h300 + 20'(i), s), 1'b0, pat(la(20'h300 + 20'(i), s)), "R9 fill set");
        w0 = wr_cnt;
        fill_chk(3'd3, 1'b0, la(20'h304, s), 1'b0, pat(la(20'h304, s)), "R9 evicting fill");
        chk(wr_cnt == w0, "R9 victim dropped", LW'(wr_cnt), LW'(w0));
        do_req(1'b1, 3'd3, 1'b0, la(20'h300, s), wdat(32'hD6D6_0006), h, d);
        chk(h == 1'b0, "R9 orphan wb misses", LW'(h), 0);
        chk(wr_cnt == w0 + 1, "R9 orphan to mem", LW'(wr_cnt), LW'(w0 + 1));
        fill_chk(3'd3, 1'b0, la(20'h300, s), 1'b0, wdat(32'hD6D6_0006), "R9 orphan not allocated");
    endtask

    bit done = 1'b0;

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_hit();
        t_wb_hit();
        t_wb_miss();
        t_noncache();
        t_replace();
        t_dirty_victim();
        t_dirty_drop();
        chk(hold_viol == 0, "R11 request held until grant", LW'(hold_viol), 0);
        chk(perr_cnt == 0, "R10 no parity error", LW'(perr_cnt), 0);
        chk(busy_viol == 0, "R12 busy and pulse", LW'(busy_viol), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule